// File: doc/BRIEF.md
# Multi-Mode VGA Scan Timing Generator

This block turns a pixel clock into the raster timing for a VGA monitor fed through an external video DAC with 8 bits per colour channel. A horizontal counter walks each line through visible pixels, front porch, sync pulse and back porch. A vertical counter steps once per finished line and walks the frame through the same four phases, counted in lines. From the two counters the block derives active-low horizontal and vertical sync, an active-high "visible" strobe for the DAC's blank pin, and the current column and row. The DAC's composite-sync pin is tied high.

A two-bit select picks one of four 60 Hz timing sets. The select is taken only while reset is held and at the clock edge where the raster returns to the top-left pixel, so a frame never mixes two timings. The four sets can be replaced as a whole through a parameter.

The colour inputs are presented to the block alongside the pixel clock. They are registered and forced to zero whenever the current pixel lies outside the visible area. All outputs come from registers fed by the same edge, so sync, blank, coordinates and colour describe the same pixel. Creating the pixel clock and drawing the picture belong to other blocks.

Top module: `vga_scan_timer`

## Requirements
- R1: While `rst_n` is low, every output edge gives `hsync_n`=1, `vsync_n`=1, `dac_blank_n`=0, `col`=0, `row`=0 and all colour outputs 0. The first edge after release shows pixel (column 0, row 0). From then on, each output reflects the counter state that was present one clock earlier.
- R2: `col` counts 0,1,…,HT-1 and then returns to 0, where HT = visible+front+sync+back pixels of the current mode. `hsync_n` is 0 exactly for columns from visible+front up to visible+front+sync-1.
- R3: `row` advances by one on the cycle where `col` returns from HT-1 to 0, and it returns to 0 after row VT-1. `vsync_n` is 0 for whole lines, from row visible+front up to visible+front+sync-1.
- R4: `dac_blank_n` is 1 exactly when `col` is below the visible pixel count and `row` is below the visible line count. It is 0 during every porch and sync interval.
- R5: When `dac_blank_n` is 1, each colour output equals the value its input had one clock earlier. When `dac_blank_n` is 0, all three colour outputs are 0.
- R6: `dac_sync_n` is 1 at all times.
- R7: With the default parameter, `mode_sel` codes give these timings (visible/front/sync/back). Code 0: horizontal 640/16/96/48, vertical 480/10/2/33. Code 1: horizontal 800/40/128/88, vertical 600/1/4/23. Code 2: horizontal 1024/24/136/160, vertical 768/3/6/29. Code 3: horizontal 1280/48/112/248, vertical 1024/1/3/38.
- R8: `mode_sel` is taken while `rst_n` is low and at the edge where the raster wraps from the last pixel of the frame to (0,0). A change at any other time has no effect until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 2 | Timing set code, taken at frame start |
| pix_r_in | input | 8 | Red value for the current pixel |
| pix_g_in | input | 8 | Green value for the current pixel |
| pix_b_in | input | 8 | Blue value for the current pixel |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| dac_blank_n | output | 1 | 1 during visible pixels, 0 while blanked |
| dac_sync_n | output | 1 | Composite sync to the DAC, held at 1 |
| dac_r | output | 8 | Red to the DAC, zero when blanked |
| dac_g | output | 8 | Green to the DAC, zero when blanked |
| dac_b | output | 8 | Blue to the DAC, zero when blanked |
| col | output | 12 | Column of the pixel on the outputs |
| row | output | 12 | Row of the pixel on the outputs |

## Verification
The assertions check, on every cycle, relations that hold in any mode. Colour is dark whenever blank is low. Neither sync pulse overlaps the visible area. The column steps by one. The row changes only when the column returns to zero. The latched mode never changes away from the top-left pixel. They cannot tell whether a porch or pulse has the right length, or whether the right timing set was chosen. The bench shows this by sweeping whole frames of small custom timing sets, with mid-frame select changes, against positions it computes itself. It also runs the first lines of each of the four real timing sets after a reset.

// File: rtl/vga_scan_pkg.sv
`timescale 1ns/1ps
// Shared widths, timing record types and the default table of four 60 Hz
// timing sets. Assumes every total fits in TW bits.
package vga_scan_pkg;

    localparam int TW        = 12;
    localparam int NUM_MODES = 4;
    localparam int MSW       = $clog2(NUM_MODES);

    // Lengths of the four phases of one axis, in pixels or lines.
    typedef struct packed {
        logic [TW-1:0] act;
        logic [TW-1:0] fp;
        logic [TW-1:0] sw;
        logic [TW-1:0] bp;
    } axis_t;

    typedef struct packed {
        axis_t h;
        axis_t v;
    } mode_t;

    typedef mode_t [NUM_MODES-1:0] mode_tab_t;

    // Builds one axis record from plain integers.
    function automatic axis_t mk_axis(int a, int f, int s, int b);
        axis_t x;
        x.act = TW'(a);
        x.fp  = TW'(f);
        x.sw  = TW'(s);
        x.bp  = TW'(b);
        return x;
    endfunction

    // Builds one mode record from horizontal then vertical lengths.
    function automatic mode_t mk_mode(int ha, int hf, int hs, int hb,
                                      int va, int vf, int vs, int vb);
        mode_t m;
        m.h = mk_axis(ha, hf, hs, hb);
        m.v = mk_axis(va, vf, vs, vb);
        return m;
    endfunction

    // Concatenation is MSB first: element 3 on the left, element 0 on the right.
    localparam mode_tab_t DEFAULT_MODES = {
        mk_mode(1280, 48, 112, 248, 1024, 1, 3, 38),
        mk_mode(1024, 24, 136, 160,  768, 3, 6, 29),
        mk_mode( 800, 40, 128,  88,  600, 1, 4, 23),
        mk_mode( 640, 16,  96,  48,  480, 10, 2, 33)
    };

endpackage

// File: rtl/vga_mode_select.sv
`timescale 1ns/1ps
// Holds the timing set used by the current frame. It loads the requested code
// during reset and at the frame-wrap edge only, and looks up its lengths.
// Assumes mode_sel is synchronous to clk.
module vga_mode_select
    import vga_scan_pkg::*;
#(
    parameter mode_tab_t MODES = DEFAULT_MODES
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [MSW-1:0] mode_sel,
    input  logic           frame_wrap,
    output logic [MSW-1:0] cur_mode,
    output mode_t          timing
);

    // Latch the requested code only where a frame begins.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_wrap) begin
            cur_mode <= mode_sel;
        end
    end

    // Table lookup for the latched code.
    always_comb begin
        timing = MODES[cur_mode];
    end

endmodule

// File: rtl/vga_phase_decode.sv
`timescale 1ns/1ps
// Decodes one axis counter into visible, sync and last-position flags from
// the four phase lengths. Phases run visible, front porch, sync, back porch.
// Assumes the sum of the lengths fits in TW bits and is at least 1.
module vga_phase_decode
    import vga_scan_pkg::*;
(
    input  logic [TW-1:0] cnt,
    input  axis_t         ax,
    output logic          active,
    output logic          sync_n,
    output logic          last
);

    logic [TW-1:0] sync_lo;
    logic [TW-1:0] sync_hi;
    logic [TW-1:0] total_m1;

    // Phase boundary positions along the axis.
    always_comb begin
        sync_lo  = ax.act + ax.fp;
        sync_hi  = sync_lo + ax.sw;
        total_m1 = sync_hi + ax.bp - TW'(1);
    end

    // Flags for the current position.
    always_comb begin
        active = (cnt < ax.act);
        sync_n = !((cnt >= sync_lo) && (cnt < sync_hi));
        last   = (cnt == total_m1);
    end

endmodule

// File: rtl/vga_axis_counter.sv
`timescale 1ns/1ps
// Position counter for one raster axis: steps when advanced, returns to zero
// after the last position. Assumes 'last' is decoded from this counter.
module vga_axis_counter
    import vga_scan_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          last,
    output logic [TW-1:0] cnt
);

    // Step or wrap the position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= last ? '0 : cnt + TW'(1);
        end
    end

endmodule

// File: rtl/vga_scan_timer.sv
`timescale 1ns/1ps
// Top of the VGA scan timing generator. Two axis counters (pixels per line,
// lines per frame) feed phase decoders. The outputs are registered so that sync,
// blank, coordinates and gated colour describe the same pixel. Assumes clk
// is the pixel clock and all inputs are synchronous to it.
module vga_scan_timer
    import vga_scan_pkg::*;
#(
    parameter int        CHW   = 8,
    parameter mode_tab_t MODES = DEFAULT_MODES
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [MSW-1:0] mode_sel,
    input  logic [CHW-1:0] pix_r_in,
    input  logic [CHW-1:0] pix_g_in,
    input  logic [CHW-1:0] pix_b_in,
    output logic           hsync_n,
    output logic           vsync_n,
    output logic           dac_blank_n,
    output logic           dac_sync_n,
    output logic [CHW-1:0] dac_r,
    output logic [CHW-1:0] dac_g,
    output logic [CHW-1:0] dac_b,
    output logic [TW-1:0]  col,
    output logic [TW-1:0]  row
);

    localparam int NAX = 2;   // axis 0: horizontal, axis 1: vertical

    logic [MSW-1:0] cur_mode;
    mode_t          cur_t;
    axis_t          ax_len [NAX];
    logic [TW-1:0]  pos    [NAX];
    logic [NAX-1:0] adv;
    logic [NAX-1:0] last;
    logic [NAX-1:0] act;
    logic [NAX-1:0] syn_n;
    logic           frame_wrap;
    logic           visible;
    logic [TW-1:0]  h_cnt;
    logic [TW-1:0]  v_cnt;

    vga_mode_select #(.MODES(MODES)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .frame_wrap (frame_wrap),
        .cur_mode   (cur_mode),
        .timing     (cur_t)
    );

    // Split the mode record per axis and chain the vertical step to line end.
    always_comb begin
        ax_len[0] = cur_t.h;
        ax_len[1] = cur_t.v;
        adv[0]    = 1'b1;
        adv[1]    = last[0];
    end

    for (genvar g = 0; g < NAX; g++) begin : g_axis
        vga_axis_counter u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv[g]),
            .last  (last[g]),
            .cnt   (pos[g])
        );
        vga_phase_decode u_dec (
            .cnt    (pos[g]),
            .ax     (ax_len[g]),
            .active (act[g]),
            .sync_n (syn_n[g]),
            .last   (last[g])
        );
    end

    // Frame-level qualifiers from both axes.
    always_comb begin
        h_cnt      = pos[0];
        v_cnt      = pos[1];
        frame_wrap = last[0] & last[1];
        visible    = act[0] & act[1];
    end

    // Register every output from the same counter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_n     <= 1'b1;
            vsync_n     <= 1'b1;
            dac_blank_n <= 1'b0;
            col         <= '0;
            row         <= '0;
            dac_r       <= '0;
            dac_g       <= '0;
            dac_b       <= '0;
        end else begin
            hsync_n     <= syn_n[0];
            vsync_n     <= syn_n[1];
            dac_blank_n <= visible;
            col         <= h_cnt;
            row         <= v_cnt;
            dac_r       <= visible ? pix_r_in : '0;
            dac_g       <= visible ? pix_g_in : '0;
            dac_b       <= visible ? pix_b_in : '0;
        end
    end

    // Composite sync is not used on the DAC side.
    assign dac_sync_n = 1'b1;

endmodule

// File: rtl/vga_scan_timer_chk.sv
`timescale 1ns/1ps
// Property checker for vga_scan_timer, bound to every instance. Observes the
// registered outputs plus the internal counters and the latched mode.
module vga_scan_timer_chk
    import vga_scan_pkg::*;
#(
    parameter int CHW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           hsync_n,
    input logic           vsync_n,
    input logic           dac_blank_n,
    input logic [CHW-1:0] dac_r,
    input logic [CHW-1:0] dac_g,
    input logic [CHW-1:0] dac_b,
    input logic [TW-1:0]  col,
    input logic [TW-1:0]  row,
    input logic [TW-1:0]  h_cnt,
    input logic [TW-1:0]  v_cnt,
    input logic [MSW-1:0] cur_mode
);

    p_dark_when_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_blank_n |-> (dac_r == '0 && dac_g == '0 && dac_b == '0));

    p_hsync_outside_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> !dac_blank_n);

    p_vsync_outside_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> !dac_blank_n);

    p_col_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (col != '0) |-> (col == $past(col) + TW'(1)));

    p_row_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (col != '0) |-> $stable(row));

    p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (col == '0 && $past(col) != '0) |-> (row == $past(row) + TW'(1) || row == '0));

    p_mode_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt != '0 || v_cnt != '0) |-> $stable(cur_mode));

endmodule

bind vga_scan_timer vga_scan_timer_chk #(.CHW(CHW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hsync_n     (hsync_n),
    .vsync_n     (vsync_n),
    .dac_blank_n (dac_blank_n),
    .dac_r       (dac_r),
    .dac_g       (dac_g),
    .dac_b       (dac_b),
    .col         (col),
    .row         (row),
    .h_cnt       (h_cnt),
    .v_cnt       (v_cnt),
    .cur_mode    (cur_mode)
);

// File: tb/vga_scan_timer_bench.sv
`timescale 1ns/1ps
// Bench: DUT 0 runs four tiny timing sets through whole frames with mid-frame
// select changes. DUT 1 runs the default sets for the first lines after reset.
module vga_scan_timer_bench;
    import vga_scan_pkg::*;

    // Bench-side timing numbers, [dut][mode].
    localparam int HA [2][4] = '{'{8, 6, 10, 4},  '{640, 800, 1024, 1280}};
    localparam int HF [2][4] = '{'{2, 1, 3, 1},   '{16, 40, 24, 48}};
    localparam int HS [2][4] = '{'{3, 2, 1, 1},   '{96, 128, 136, 112}};
    localparam int HB [2][4] = '{'{2, 3, 1, 1},   '{48, 88, 160, 248}};
    localparam int VA [2][4] = '{'{4, 3, 5, 2},   '{480, 600, 768, 1024}};
    localparam int VF [2][4] = '{'{1, 2, 1, 1},   '{10, 1, 3, 1}};
    localparam int VS [2][4] = '{'{2, 1, 1, 1},   '{2, 4, 6, 3}};
    localparam int VB [2][4] = '{'{1, 2, 3, 1},   '{33, 23, 29, 38}};

    localparam mode_tab_t TINY = {
        mk_mode(4, 1, 1, 1, 2, 1, 1, 1),
        mk_mode(10, 3, 1, 1, 5, 1, 1, 3),
        mk_mode(6, 1, 2, 3, 3, 2, 1, 2),
        mk_mode(8, 2, 3, 2, 4, 1, 2, 1)
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] msel [2];
    logic [7:0] pr = '0, pg = '0, pb = '0;
    logic [7:0] prev_r = '0, prev_g = '0, prev_b = '0;
    logic [7:0] seq = '0;

    logic [1:0] hs_o, vs_o, bl_o, cs_o;
    logic [7:0] r_o [2], g_o [2], b_o [2];
    logic [TW-1:0] col_o [2], row_o [2];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int mh [2], mv [2], mm [2];

    always #2.5 clk = ~clk;

    vga_scan_timer #(.CHW(8), .MODES(TINY)) u_vga_scan_timer (
        .clk(clk), .rst_n(rst_n), .mode_sel(msel[0]),
        .pix_r_in(pr), .pix_g_in(pg), .pix_b_in(pb),
        .hsync_n(hs_o[0]), .vsync_n(vs_o[0]), .dac_blank_n(bl_o[0]),
        .dac_sync_n(cs_o[0]), .dac_r(r_o[0]), .dac_g(g_o[0]), .dac_b(b_o[0]),
        .col(col_o[0]), .row(row_o[0])
    );

    vga_scan_timer #(.CHW(8)) u_full (
        .clk(clk), .rst_n(rst_n), .mode_sel(msel[1]),
        .pix_r_in(pr), .pix_g_in(pg), .pix_b_in(pb),
        .hsync_n(hs_o[1]), .vsync_n(vs_o[1]), .dac_blank_n(bl_o[1]),
        .dac_sync_n(cs_o[1]), .dac_r(r_o[1]), .dac_g(g_o[1]), .dac_b(b_o[1]),
        .col(col_o[1]), .row(row_o[1])
    );

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare one DUT against the bench's own position, then advance it.
    task automatic check_dut(int d);
        int m = mm[d];
        int h = mh[d];
        int v = mv[d];
        int hl = HA[d][m] + HF[d][m];
        int vl = VA[d][m] + VF[d][m];
        bit vis = (h < HA[d][m]) && (v < VA[d][m]);
        bit ehs = !((h >= hl) && (h < hl + HS[d][m]));
        bit evs = !((v >= vl) && (v < vl + VS[d][m]));
        string th = (d == 1) ? "R7" : ((int'(msel[0]) != m) ? "R8" : "R2");
        string tv = (d == 1) ? "R7" : ((int'(msel[0]) != m) ? "R8" : "R3");
        string tb = (d == 1) ? "R7" : ((int'(msel[0]) != m) ? "R8" : "R4");
        chk(th, "col", int'(col_o[d]), h);
        chk(th, "hsync_n", int'(hs_o[d]), int'(ehs));
        chk(tv, "row", int'(row_o[d]), v);
        chk(tv, "vsync_n", int'(vs_o[d]), int'(evs));
        chk(tb, "dac_blank_n", int'(bl_o[d]), int'(vis));
        chk("R5", "dac_r", int'(r_o[d]), vis ? int'(prev_r) : 0);
        chk("R5", "dac_g", int'(g_o[d]), vis ? int'(prev_g) : 0);
        chk("R5", "dac_b", int'(b_o[d]), vis ? int'(prev_b) : 0);
        chk("R6", "dac_sync_n", int'(cs_o[d]), 1);
        // advance to the position the design now holds (R3 line/frame wrap, R8 load)
        if (h == HA[d][m] + HF[d][m] + HS[d][m] + HB[d][m] - 1) begin
            mh[d] = 0;
            if (v == VA[d][m] + VF[d][m] + VS[d][m] + VB[d][m] - 1) begin
                mv[d] = 0;
                mm[d] = int'(msel[d]);
            end else begin
                mv[d] = v + 1;
            end
        end else begin
            mh[d] = h + 1;
        end
    endtask

    // Drive fresh colour values, remembering what the next edge samples.
    task automatic drive_pix();
        seq = seq + 8'd37;
        pr = seq;
        pg = seq ^ 8'h5a;
        pb = ~seq;
        prev_r = pr;
        prev_g = pg;
        prev_b = pb;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_dut(0);
            check_dut(1);
            drive_pix();
        end
    endtask

    // Reset both DUTs, check the held state, then release (R1).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive_pix();
        repeat (3) @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            chk("R1", "reset hsync_n", int'(hs_o[d]), 1);
            chk("R1", "reset vsync_n", int'(vs_o[d]), 1);
            chk("R1", "reset blank_n", int'(bl_o[d]), 0);
            chk("R1", "reset col", int'(col_o[d]), 0);
            chk("R1", "reset row", int'(row_o[d]), 0);
            chk("R1", "reset rgb", int'(r_o[d]) + int'(g_o[d]) + int'(b_o[d]), 0);
            mh[d] = 0;
            mv[d] = 0;
            mm[d] = int'(msel[d]);
        end
        rst_n = 1'b1;
    endtask

    initial begin
        msel[0] = 2'd0;
        msel[1] = 2'd0;
        do_reset();
        // R1: first edge after release shows pixel (0,0), checked by run
        run(60);
        msel[0] = 2'd2;           // R8: mid-frame change, frame 0 stays mode 0
        run(200);
        msel[0] = 2'd1;
        run(400);
        msel[0] = 2'd3;
        run(300);
        msel[0] = 2'd0;
        run(300);
        msel[0] = 2'd2;
        run(1000);
        // R7: first two lines of each default timing set
        for (int m = 0; m < 4; m++) begin
            msel[1] = 2'(m);
            do_reset();
            run(2 * (HA[1][m] + HF[1][m] + HS[1][m] + HB[1][m]) + 5);
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule